// File: doc/BRIEF.md
# Asynchronous Interrupt Pending Arbiter

This block sits beside a processor's exception-entry logic. It keeps track of asynchronous interrupt causes and decides when one of them is handed to that logic. Three causes are tracked:

- An external interrupt line. Its pending state mirrors the line level, so it stays pending for as long as the line is held.
- A decrementer-expiry pulse. This latches a one-shot pending flag.
- A floating-point enabled-exception condition. It is formed from the two machine-state floating-point exception mode bits and the floating-point status summary bit.

When a cause is eligible, the block raises a delivery request. The request carries the vector offset of the chosen cause and the bits that the exception entry must OR into the saved machine-state register. It holds all of these until the entry logic acknowledges.

Only one delivery is outstanding at any time. Triggers that arrive while a request is held are absorbed into the current request and are looked at again afterwards. Priority is settled once more on the cycle after each acknowledge. Exception entry is expected to clear the external-enable bit. Because of that, the external and decrementer causes are not delivered again until software sets the bit once more.

Top module: `irq_pend_arbiter`

## Requirements
- R1: When either floating-point mode bit (msr_fe_mode[0] or msr_fe_mode[1]) is 1 and fpscr_fex is 1, a delivery is made to offset 0x700. It carries dlv_srr1 bits 20 (enabled-exception) and 16 (subsequent-instruction) set and all other bits clear. It takes this delivery even when msr_ext_en is 0, and it outranks every other cause.
- R2: With msr_ext_en at 1 and no floating-point condition, a pending external interrupt is delivered to offset 0x500 ahead of a pending decrementer interrupt.
- R3: A decrementer delivery uses offset 0x900. Acknowledging that delivery clears pend_dec, so it is delivered only once per event.
- R4: pend_ext takes the value of ext_irq_line one clock later. A delivery or its acknowledge never clears it. It clears only when the line is low.
- R5: dec_expired sets pend_dec even while msr_ext_en is 0. While msr_ext_en stays 0, no external or decrementer delivery is made.
- R6: dlv_req stays high, with dlv_vec and dlv_srr1 unchanged, until dlv_ack is seen. It is low in the cycle after the acknowledge edge, and priority is evaluated again at the next edge.
- R7: Only one delivery is outstanding. An event that arrives while dlv_req is high does not disturb the current request and stays pending for a later delivery.
- R8: dlv_req rises at the first clock edge at which a cause is eligible. This is one edge after an enable or floating-point input change, and two edges after a rise of ext_irq_line or a dec_expired pulse.
- R9: While rst is high, dlv_req, pend_ext and pend_dec are 0.
- R10: For external and decrementer deliveries, dlv_srr1 is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_line | input | 1 | External interrupt level |
| dec_expired | input | 1 | One-cycle decrementer expiry pulse |
| msr_ext_en | input | 1 | Machine-state external interrupt enable |
| msr_fe_mode | input | 2 | Machine-state floating-point exception mode bits |
| fpscr_fex | input | 1 | Floating-point enabled-exception summary |
| dlv_ack | input | 1 | Exception entry accepted the request |
| dlv_req | output | 1 | Delivery request, held until acknowledged |
| dlv_vec | output | 12 | Vector offset of the requested delivery |
| dlv_srr1 | output | 32 | Bits to OR into the saved machine state |
| pend_ext | output | 1 | External interrupt pending |
| pend_dec | output | 1 | Decrementer interrupt pending |

## Verification
A change to the enable or floating-point inputs shows up on dlv_req one edge later. A rise of the external line or a decrementer pulse takes two edges, because the pending register lies in between. pend_ext and pend_dec move one edge after their stimulus, and an acknowledge drops the request at that same edge. The bench drives inputs on falling edges and reads every output exactly that number of falling edges later. A scoreboard queue holds the vector and saved-state bits expected for each rising request, in the order the stimulus implies.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    parameter int VEC_W         = 12;
    parameter int SRR1_W        = 32;
    parameter int FE_W          = 2;
    parameter int SRR1_FPE_BIT  = 20;
    parameter int SRR1_NEXT_BIT = 16;

    localparam logic [VEC_W-1:0] VEC_FPE = VEC_W'(12'h700);
    localparam logic [VEC_W-1:0] VEC_EXT = VEC_W'(12'h500);
    localparam logic [VEC_W-1:0] VEC_DEC = VEC_W'(12'h900);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FPE  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_DEC  = 2'd3
    } irq_src_e;

    typedef struct packed {
        irq_src_e            src;
        logic [VEC_W-1:0]    vec;
        logic [SRR1_W-1:0]   srr1;
    } irq_pick_t;

    function automatic irq_pick_t make_pick(irq_src_e s);
        irq_pick_t p;
        p.src  = s;
        p.vec  = '0;
        p.srr1 = '0;
        case (s)
            SRC_FPE: begin
                p.vec = VEC_FPE;
                p.srr1[SRR1_FPE_BIT]  = 1'b1;
                p.srr1[SRR1_NEXT_BIT] = 1'b1;
            end
            SRC_EXT: p.vec = VEC_EXT;
            SRC_DEC: p.vec = VEC_DEC;
            default: p.vec = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track (
    input  logic clk,
    input  logic rst,
    input  logic ext_line,
    input  logic dec_tick,
    input  logic clr_dec,
    output logic ext_pend,
    output logic dec_pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_pend <= 1'b0;
            dec_pend <= 1'b0;
        end else begin
            ext_pend <= ext_line;
            if (dec_tick)
                dec_pend <= 1'b1;
            else if (clr_dec)
                dec_pend <= 1'b0;
        end
    end

    // R5: a latched decrementer event survives until its own delivery is taken
    p_dec_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (dec_pend && !clr_dec) |=> dec_pend);

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_arb_pkg::*;
(
    input  logic [FE_W-1:0] fe_mode,
    input  logic            fex,
    input  logic            ext_en,
    input  logic            ext_pend,
    input  logic            dec_pend,
    output irq_pick_t       pick,
    output logic            valid
);

    logic     fp_hit;
    irq_src_e src;

    always_comb begin
        fp_hit = (|fe_mode) && fex;
        if (fp_hit)
            src = SRC_FPE;
        else if (ext_en && ext_pend)
            src = SRC_EXT;
        else if (ext_en && dec_pend)
            src = SRC_DEC;
        else
            src = SRC_NONE;
        pick  = make_pick(src);
        valid = (src != SRC_NONE);
    end

endmodule

// File: rtl/irq_dlv_seq.sv
module irq_dlv_seq
    import irq_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cand_valid,
    input  irq_pick_t cand,
    input  logic      ack,
    output logic      req,
    output irq_pick_t held
);

    typedef enum logic {ST_IDLE, ST_BUSY} seq_st_e;
    seq_st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            held <= make_pick(SRC_NONE);
        end else begin
            case (st)
                ST_IDLE: if (cand_valid) begin
                    held <= cand;
                    st   <= ST_BUSY;
                end
                ST_BUSY: if (ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req = (st == ST_BUSY);

    // R6: request and its payload are frozen until acknowledged
    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (req && !ack) |=> (req && $stable(held)));

    // R6: acknowledge always leaves one idle cycle before re-arbitration
    p_gap_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (req && ack) |=> !req);

endmodule

// File: rtl/irq_pend_arbiter.sv
module irq_pend_arbiter
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_irq_line,
    input  logic                dec_expired,
    input  logic                msr_ext_en,
    input  logic [FE_W-1:0]     msr_fe_mode,
    input  logic                fpscr_fex,
    input  logic                dlv_ack,
    output logic                dlv_req,
    output logic [VEC_W-1:0]    dlv_vec,
    output logic [SRR1_W-1:0]   dlv_srr1,
    output logic                pend_ext,
    output logic                pend_dec
);

    irq_pick_t cand;
    irq_pick_t held;
    logic      cand_valid;
    logic      clr_dec;

    assign clr_dec = dlv_req && dlv_ack && (held.src == SRC_DEC);

    irq_pend_track u_track (
        .clk      (clk),
        .rst      (rst),
        .ext_line (ext_irq_line),
        .dec_tick (dec_expired),
        .clr_dec  (clr_dec),
        .ext_pend (pend_ext),
        .dec_pend (pend_dec)
    );

    irq_prio_sel u_sel (
        .fe_mode  (msr_fe_mode),
        .fex      (fpscr_fex),
        .ext_en   (msr_ext_en),
        .ext_pend (pend_ext),
        .dec_pend (pend_dec),
        .pick     (cand),
        .valid    (cand_valid)
    );

    irq_dlv_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cand_valid (cand_valid),
        .cand       (cand),
        .ack        (dlv_ack),
        .req        (dlv_req),
        .held       (held)
    );

    assign dlv_vec  = held.vec;
    assign dlv_srr1 = held.srr1;

    // R1: a floating-point delivery carries both saved-state flags
    p_fp_bits_r1: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_vec == VEC_FPE) |->
            (dlv_srr1[SRR1_FPE_BIT] && dlv_srr1[SRR1_NEXT_BIT]));

    // R10: external and decrementer deliveries add no saved-state bits
    p_plain_srr1_r10: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_vec != VEC_FPE) |-> (dlv_srr1 == '0));

    // R3: decrementer pending is gone after its delivery is taken
    p_dec_once_r3: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_ack && dlv_vec == VEC_DEC && !dec_expired) |=> !pend_dec);

    // R4: taking an external delivery leaves it pending while the line holds
    p_ext_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (dlv_req && dlv_ack && dlv_vec == VEC_EXT && ext_irq_line) |=> pend_ext);

endmodule

// File: tb/tb_irq_pend_arbiter.sv
module tb_irq_pend_arbiter;
    import irq_arb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ext_irq_line = 1'b0;
    logic              dec_expired = 1'b0;
    logic              msr_ext_en = 1'b0;
    logic [FE_W-1:0]   msr_fe_mode = '0;
    logic              fpscr_fex = 1'b0;
    logic              dlv_ack = 1'b0;
    logic              dlv_req;
    logic [VEC_W-1:0]  dlv_vec;
    logic [SRR1_W-1:0] dlv_srr1;
    logic              pend_ext;
    logic              pend_dec;

    always #2 clk = ~clk;

    irq_pend_arbiter dut (
        .clk(clk), .rst(rst), .ext_irq_line(ext_irq_line), .dec_expired(dec_expired),
        .msr_ext_en(msr_ext_en), .msr_fe_mode(msr_fe_mode), .fpscr_fex(fpscr_fex),
        .dlv_ack(dlv_ack), .dlv_req(dlv_req), .dlv_vec(dlv_vec), .dlv_srr1(dlv_srr1),
        .pend_ext(pend_ext), .pend_dec(pend_dec)
    );

    typedef struct { logic [31:0] vec; logic [31:0] srr1; } exp_t;
    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic prev_req = 1'b0;

    localparam logic [31:0] FP_BITS = (32'd1 << SRR1_FPE_BIT) | (32'd1 << SRR1_NEXT_BIT);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_dlv(input logic [31:0] v, input logic [31:0] s);
        exp_t e;
        e.vec = v;
        e.srr1 = s;
        q.push_back(e);
    endtask

    // monitor: every new request is matched against the scoreboard head
    always @(negedge clk) begin
        if (!rst) begin
            if (dlv_req && !prev_req) begin
                if (q.size() == 0) begin
                    chk("R7 unexpected delivery", 32'(dlv_vec), 32'hFFFF);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R1/R2/R3 scoreboard vec", 32'(dlv_vec), e.vec);
                    chk("R1/R10 scoreboard srr1", dlv_srr1, e.srr1);
                end
            end
            prev_req = dlv_req;
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(2);
        chk("R9 reset req", 32'(dlv_req), 0);
        chk("R9 reset pend_ext", 32'(pend_ext), 0);
        chk("R9 reset pend_dec", 32'(pend_dec), 0);
        rst = 1'b0;
        step(1);

        // external pending while disabled
        ext_irq_line = 1'b1;
        step(1);
        chk("R4 ext follows line", 32'(pend_ext), 1);
        step(1);
        chk("R5 no delivery while disabled", 32'(dlv_req), 0);
        expect_dlv(32'h500, 0);
        msr_ext_en = 1'b1;
        step(1);
        chk("R8 req one edge after enable", 32'(dlv_req), 1);
        dec_expired = 1'b1;
        step(1);
        dec_expired = 1'b0;
        chk("R7 event latched during request", 32'(pend_dec), 1);
        chk("R7 request undisturbed", 32'(dlv_vec), 32'h500);
        step(2);
        chk("R6 req held", 32'(dlv_req), 1);
        chk("R6 vec held", 32'(dlv_vec), 32'h500);
        dlv_ack = 1'b1; msr_ext_en = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        chk("R6 req drops after ack", 32'(dlv_req), 0);
        chk("R4 ext kept after delivery", 32'(pend_ext), 1);
        chk("R7 dec still pending", 32'(pend_dec), 1);
        ext_irq_line = 1'b0;
        step(1);
        chk("R4 ext clears with line", 32'(pend_ext), 0);
        step(2);
        chk("R5 nothing while disabled", 32'(dlv_req), 0);
        expect_dlv(32'h900, 0);
        msr_ext_en = 1'b1;
        step(1);
        chk("R3 dec delivered", 32'(dlv_vec), 32'h900);
        dlv_ack = 1'b1; msr_ext_en = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        chk("R3 dec cleared on ack", 32'(pend_dec), 0);
        msr_ext_en = 1'b1;
        step(4);
        chk("R3 dec once only", 32'(dlv_req), 0);
        msr_ext_en = 1'b0;

        // floating-point outranks a pending external
        ext_irq_line = 1'b1;
        step(2);
        expect_dlv(32'h700, FP_BITS);
        expect_dlv(32'h500, 0);
        msr_ext_en = 1'b1; msr_fe_mode = 2'b10; fpscr_fex = 1'b1;
        step(1);
        chk("R1 fp wins vec", 32'(dlv_vec), 32'h700);
        chk("R1 fp srr1", dlv_srr1, FP_BITS);
        dlv_ack = 1'b1; fpscr_fex = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        chk("R6 gap after ack", 32'(dlv_req), 0);
        step(1);
        chk("R6 re-evaluated to ext", 32'(dlv_req), 1);
        chk("R2 ext next", 32'(dlv_vec), 32'h500);
        dlv_ack = 1'b1; msr_ext_en = 1'b0; ext_irq_line = 1'b0; msr_fe_mode = 2'b00;
        step(1);
        dlv_ack = 1'b0;
        step(2);
        chk("R6 idle after ack", 32'(dlv_req), 0);

        // floating-point with external enable clear
        expect_dlv(32'h700, FP_BITS);
        msr_fe_mode = 2'b01; fpscr_fex = 1'b1;
        step(1);
        chk("R1 fp ignores enable", 32'(dlv_req), 1);
        dlv_ack = 1'b1; fpscr_fex = 1'b0; msr_fe_mode = 2'b00;
        step(1);
        dlv_ack = 1'b0;
        step(2);
        chk("R1 no repeat", 32'(dlv_req), 0);

        // decrementer deferred until enabled
        dec_expired = 1'b1;
        step(1);
        dec_expired = 1'b0;
        step(3);
        chk("R5 dec pending while disabled", 32'(pend_dec), 1);
        chk("R5 dec deferred", 32'(dlv_req), 0);
        expect_dlv(32'h900, 0);
        msr_ext_en = 1'b1;
        step(1);
        chk("R8 dec req after enable", 32'(dlv_vec), 32'h900);
        dlv_ack = 1'b1; msr_ext_en = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        chk("R3 dec cleared", 32'(pend_dec), 0);

        // both pending: external first, then decrementer
        ext_irq_line = 1'b1; dec_expired = 1'b1;
        step(1);
        dec_expired = 1'b0;
        step(1);
        expect_dlv(32'h500, 0);
        expect_dlv(32'h900, 0);
        msr_ext_en = 1'b1;
        step(1);
        chk("R2 ext before dec", 32'(dlv_vec), 32'h500);
        dlv_ack = 1'b1; ext_irq_line = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        chk("R7 dec kept for later", 32'(pend_dec), 1);
        step(1);
        chk("R2 dec follows", 32'(dlv_vec), 32'h900);
        dlv_ack = 1'b1; msr_ext_en = 1'b0;
        step(1);
        dlv_ack = 1'b0;
        step(2);
        chk("R7 no extra deliveries", 32'(dlv_req), 0);
        chk("R7 scoreboard drained", 32'(q.size()), 0);

        finish_run();
    end

endmodule